// File: doc/BRIEF.md
# Register Result Status Rename Table

This block sits beside a floating-point register file in a dynamically scheduled pipeline. For every architectural register it holds a small status field. The field names the reservation station that will produce the next value of that register, or holds zero when no pending instruction targets the register. It also holds the register's committed value. When an instruction issues, the table answers two source lookups. A source whose status is nonzero comes back as a producer tag for the station to wait on. Otherwise the register value itself comes back.

On the same issue the destination register's status is overwritten with the issuing station's tag. An older producer that is still in flight is simply forgotten, and this in-place replacement is what renames registers. The table also snoops the result broadcast bus, which carries a 64-bit value and a 4-bit producer tag. A register takes a broadcast only while its status still equals the broadcast tag. The same edge that writes the value clears the status. Results from superseded producers are dropped.

Lookups are combinational and see a broadcast arriving in the same cycle. A lookup reads the table as it stood before the current issue's rename, so an instruction that reads and writes the same register gets the older producer.

Top module: `rename_status_table`

## Requirements
- R1: After reset every register's status is zero and its value is zero, so every source lookup returns tag 0 and value 0.
- R2: A source lookup of a register whose status is zero returns tag 0 and the register's stored value.
- R3: A source lookup of a register whose status is nonzero, with no matching broadcast that cycle, returns that status as the tag and a value of zero.
- R4: An issue (iss_valid high) sets the destination register's status to iss_tag at the next clock edge, replacing any earlier nonzero status.
- R5: A broadcast whose nonzero tag equals a register's status writes bc_data into that register and clears its status to zero at the same clock edge.
- R6: A broadcast whose tag differs from a register's status leaves that register's value and status unchanged.
- R7: When an issue renames a register whose current status matches the tag being broadcast in the same cycle, the status after the edge is the new issue tag, not zero.
- R8: A source lookup of a register whose status matches the tag broadcast in the same cycle returns tag 0 and the broadcast data.
- R9: A broadcast carrying tag 0 writes no register, including registers whose status is already zero.
- R10: Source lookups in an issue cycle reflect the state before that issue's rename, even when a source equals the destination.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| iss_valid | input | 1 | An instruction issues this cycle |
| iss_tag | input | 4 | Tag of the issuing station (nonzero) |
| iss_dst | input | 4 | Destination register index |
| iss_src_a | input | 4 | First source register index |
| iss_src_b | input | 4 | Second source register index |
| bc_valid | input | 1 | Result broadcast present |
| bc_tag | input | 4 | Producer tag of the broadcast |
| bc_data | input | 64 | Broadcast result value |
| src_a_tag | output | 4 | Producer tag for first source, 0 when value is ready |
| src_a_val | output | 64 | Value for first source, 0 while pending |
| src_b_tag | output | 4 | Producer tag for second source, 0 when value is ready |
| src_b_val | output | 64 | Value for second source, 0 while pending |

## Verification
Issue and broadcast can land in the same cycle in two ways. A lookup can hit the register being completed. A rename can hit the register whose producer is broadcasting. The bench provokes the first by sampling the source outputs just before the edge of a broadcast cycle, expecting tag 0 and the bus data. It provokes the second by renaming a register while its old producer broadcasts, then checking one cycle later that the new tag is still pending. A stale broadcast from a replaced producer is also driven, and the untouched register is read back afterwards.

// File: rtl/rrs_pkg.sv
package rrs_pkg;
  localparam int TAG_W  = 4;
  localparam int DATA_W = 64;

  typedef logic [TAG_W-1:0]  tag_t;
  typedef logic [DATA_W-1:0] data_t;

  // A broadcast completes a register only while the register still waits on that tag.
  function automatic logic tag_hit(input logic valid, input tag_t bus_tag, input tag_t status);
    return valid && (status != '0) && (status == bus_tag);
  endfunction

  // Lookup result for one source: bypass, pending or ready.
  function automatic tag_t pick_tag(input logic hit, input tag_t status);
    return hit ? '0 : status;
  endfunction

  function automatic data_t pick_val(input logic hit, input tag_t status,
                                     input data_t stored, input data_t bus);
    if (hit)               return bus;
    else if (status != '0) return '0;
    else                   return stored;
  endfunction
endpackage

// File: rtl/rrs_entry.sv
module rrs_entry
  import rrs_pkg::*;
#(
  parameter int IDX   = 0,
  parameter int REG_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             iss_valid,
  input  tag_t             iss_tag,
  input  logic [REG_W-1:0] iss_dst,
  input  logic             bc_valid,
  input  tag_t             bc_tag,
  input  data_t            bc_data,
  output tag_t             status,
  output data_t            value,
  output logic             hit
);
  logic rename;

  assign hit    = tag_hit(bc_valid, bc_tag, status);
  assign rename = iss_valid && (iss_dst == REG_W'(IDX));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      status <= '0;
      value  <= '0;
    end else begin
      if (hit)
        value <= bc_data;
      if (rename)
        status <= iss_tag;
      else if (hit)
        status <= '0;
    end
  end

  AST_CLEAR_ON_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && !rename) |=> (status == '0 && value == $past(bc_data))); // R5

  AST_RENAME_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    rename |=> (status == $past(iss_tag))); // R4 R7

  AST_STALE_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (bc_valid && bc_tag != status && !rename) |=> ($stable(status) && $stable(value))); // R6

  AST_ZERO_TAG_NOWRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (bc_valid && bc_tag == '0) |=> $stable(value)); // R9
endmodule

// File: rtl/rrs_read_port.sv
module rrs_read_port
  import rrs_pkg::*;
#(
  parameter int NREGS = 16,
  parameter int REG_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [REG_W-1:0] sel,
  input  tag_t             status [NREGS],
  input  data_t            value  [NREGS],
  input  logic             hit    [NREGS],
  input  data_t            bc_data,
  output tag_t             out_tag,
  output data_t            out_val
);
  tag_t  sel_status;
  data_t sel_value;
  logic  sel_hit;

  assign sel_status = status[sel];
  assign sel_value  = value[sel];
  assign sel_hit    = hit[sel];
  assign out_tag    = pick_tag(sel_hit, sel_status);
  assign out_val    = pick_val(sel_hit, sel_status, sel_value, bc_data);

  AST_BYPASS_READY: assert property (@(posedge clk) disable iff (!rst_n)
    sel_hit |-> (out_tag == '0 && out_val == bc_data)); // R8

  AST_PENDING_HIDDEN: assert property (@(posedge clk) disable iff (!rst_n)
    (out_tag != '0) |-> (out_val == '0 && !sel_hit)); // R3
endmodule

// File: rtl/rename_status_table.sv
module rename_status_table
  import rrs_pkg::*;
#(
  parameter int NREGS = 16,
  localparam int REG_W = $clog2(NREGS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             iss_valid,
  input  logic [3:0]       iss_tag,
  input  logic [REG_W-1:0] iss_dst,
  input  logic [REG_W-1:0] iss_src_a,
  input  logic [REG_W-1:0] iss_src_b,
  input  logic             bc_valid,
  input  logic [3:0]       bc_tag,
  input  logic [63:0]      bc_data,
  output logic [3:0]       src_a_tag,
  output logic [63:0]      src_a_val,
  output logic [3:0]       src_b_tag,
  output logic [63:0]      src_b_val
);
  tag_t  status [NREGS];
  data_t value  [NREGS];
  logic  hit    [NREGS];

  for (genvar g = 0; g < NREGS; g++) begin : g_reg
    rrs_entry #(.IDX(g), .REG_W(REG_W)) u_entry (
      .clk(clk), .rst_n(rst_n),
      .iss_valid(iss_valid), .iss_tag(iss_tag), .iss_dst(iss_dst),
      .bc_valid(bc_valid), .bc_tag(bc_tag), .bc_data(bc_data),
      .status(status[g]), .value(value[g]), .hit(hit[g])
    );
  end

  rrs_read_port #(.NREGS(NREGS), .REG_W(REG_W)) u_port_a (
    .clk(clk), .rst_n(rst_n), .sel(iss_src_a),
    .status(status), .value(value), .hit(hit), .bc_data(bc_data),
    .out_tag(src_a_tag), .out_val(src_a_val)
  );

  rrs_read_port #(.NREGS(NREGS), .REG_W(REG_W)) u_port_b (
    .clk(clk), .rst_n(rst_n), .sel(iss_src_b),
    .status(status), .value(value), .hit(hit), .bc_data(bc_data),
    .out_tag(src_b_tag), .out_val(src_b_val)
  );

  AST_ISSUE_TAG_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    iss_valid |-> (iss_tag != '0)); // R4
endmodule

// File: tb/test_rename_status_table.sv
module test_rename_status_table;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        iss_valid;
  logic [3:0]  iss_tag, iss_dst, iss_src_a, iss_src_b;
  logic        bc_valid;
  logic [3:0]  bc_tag;
  logic [63:0] bc_data;
  logic [3:0]  src_a_tag, src_b_tag;
  logic [63:0] src_a_val, src_b_val;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  always #10 clk = ~clk;

  rename_status_table i_rename_status_table (
    .clk(clk), .rst_n(rst_n),
    .iss_valid(iss_valid), .iss_tag(iss_tag), .iss_dst(iss_dst),
    .iss_src_a(iss_src_a), .iss_src_b(iss_src_b),
    .bc_valid(bc_valid), .bc_tag(bc_tag), .bc_data(bc_data),
    .src_a_tag(src_a_tag), .src_a_val(src_a_val),
    .src_b_tag(src_b_tag), .src_b_val(src_b_val)
  );

  typedef struct packed {
    logic        iv;
    logic [3:0]  itag, dst, sa, sb;
    logic        bv;
    logic [3:0]  btag;
    logic [15:0] bdata;
    logic [3:0]  ea_tag;
    logic [15:0] ea_val;
    logic [3:0]  eb_tag;
    logic [15:0] eb_val;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 4'd5, 4'd2, 4'd2, 4'd3, 1'b0, 4'd0, 16'h0000, 4'd0, 16'h0000, 4'd0, 16'h0000, 8'd10}, // R10 R2
    '{1'b1, 4'd6, 4'd4, 4'd2, 4'd4, 1'b0, 4'd0, 16'h0000, 4'd5, 16'h0000, 4'd0, 16'h0000, 8'd3},  // R3 R4
    '{1'b1, 4'd7, 4'd2, 4'd1, 4'd1, 1'b0, 4'd0, 16'h0000, 4'd0, 16'h0000, 4'd0, 16'h0000, 8'd2},  // R4 rename over 5
    '{1'b0, 4'd0, 4'd0, 4'd2, 4'd4, 1'b1, 4'd5, 16'hAAAA, 4'd7, 16'h0000, 4'd6, 16'h0000, 8'd6},  // R6 stale tag 5
    '{1'b0, 4'd0, 4'd0, 4'd4, 4'd2, 1'b1, 4'd6, 16'h1234, 4'd0, 16'h1234, 4'd7, 16'h0000, 8'd8},  // R8 bypass
    '{1'b0, 4'd0, 4'd0, 4'd4, 4'd2, 1'b0, 4'd0, 16'h0000, 4'd0, 16'h1234, 4'd7, 16'h0000, 8'd5},  // R5 R6
    '{1'b1, 4'd8, 4'd2, 4'd3, 4'd3, 1'b1, 4'd7, 16'h0777, 4'd0, 16'h0000, 4'd0, 16'h0000, 8'd7},  // R7 collide
    '{1'b0, 4'd0, 4'd0, 4'd2, 4'd2, 1'b0, 4'd0, 16'h0000, 4'd8, 16'h0000, 4'd8, 16'h0000, 8'd7},  // R7 new tag held
    '{1'b0, 4'd0, 4'd0, 4'd2, 4'd5, 1'b1, 4'd8, 16'h0888, 4'd0, 16'h0888, 4'd0, 16'h0000, 8'd8},  // R8
    '{1'b0, 4'd0, 4'd0, 4'd0, 4'd2, 1'b1, 4'd0, 16'hFFFF, 4'd0, 16'h0000, 4'd0, 16'h0888, 8'd9},  // R9
    '{1'b0, 4'd0, 4'd0, 4'd0, 4'd2, 1'b0, 4'd0, 16'h0000, 4'd0, 16'h0000, 4'd0, 16'h0888, 8'd9},  // R9 R5
    '{1'b1, 4'd9, 4'd4, 4'd4, 4'd4, 1'b0, 4'd0, 16'h0000, 4'd0, 16'h1234, 4'd0, 16'h1234, 8'd10}, // R10
    '{1'b0, 4'd0, 4'd0, 4'd4, 4'd2, 1'b0, 4'd0, 16'h0000, 4'd9, 16'h0000, 4'd0, 16'h0888, 8'd3}   // R3
  };

  task automatic chk(input string req, input string port, input logic [3:0] gt, input logic [3:0] et,
                     input logic [63:0] gv, input logic [63:0] ev);
    checks++;
    if (gt !== et || gv !== ev) begin
      errors++;
      $display("FAIL %s port %s: tag=%0d val=%h expected tag=%0d val=%h", req, port, gt, gv, et, ev);
    end
  endtask

  task automatic idle();
    iss_valid = 0; iss_tag = 0; iss_dst = 0; iss_src_a = 0; iss_src_b = 0;
    bc_valid = 0; bc_tag = 0; bc_data = '0;
  endtask

  initial begin
    #(20 * 5000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    idle();
    rst_n = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;

    // R1: reset state seen through lookups
    iss_src_a = 4'd0; iss_src_b = 4'd15;
    #5;
    chk("R1", "a", src_a_tag, 4'd0, src_a_val, 64'd0);
    chk("R1", "b", src_b_tag, 4'd0, src_b_val, 64'd0);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      iss_valid = VECS[i].iv; iss_tag = VECS[i].itag; iss_dst = VECS[i].dst;
      iss_src_a = VECS[i].sa; iss_src_b = VECS[i].sb;
      bc_valid = VECS[i].bv; bc_tag = VECS[i].btag; bc_data = {48'd0, VECS[i].bdata};
      #5;
      chk($sformatf("R%0d vec%0d", VECS[i].req, i), "a", src_a_tag, VECS[i].ea_tag,
          src_a_val, {48'd0, VECS[i].ea_val});
      chk($sformatf("R%0d vec%0d", VECS[i].req, i), "b", src_b_tag, VECS[i].eb_tag,
          src_b_val, {48'd0, VECS[i].eb_val});
    end

    // R5: full-width value lands in the last register
    @(negedge clk);
    idle(); iss_valid = 1; iss_tag = 4'd15; iss_dst = 4'd15;
    @(negedge clk);
    idle(); bc_valid = 1; bc_tag = 4'd15; bc_data = 64'hDEAD_BEEF_0123_4567;
    @(negedge clk);
    idle(); iss_src_a = 4'd15; iss_src_b = 4'd4;
    #5;
    chk("R5", "a", src_a_tag, 4'd0, src_a_val, 64'hDEAD_BEEF_0123_4567);
    chk("R3", "b", src_b_tag, 4'd9, src_b_val, 64'd0);

    // R1: reset in mid-run clears pending status and values
    @(negedge clk);
    rst_n = 0;
    @(negedge clk);
    rst_n = 1; iss_src_a = 4'd4; iss_src_b = 4'd15;
    #5;
    chk("R1", "a", src_a_tag, 4'd0, src_a_val, 64'd0);
    chk("R1", "b", src_b_tag, 4'd0, src_b_val, 64'd0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule